// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer that software must service inside a bounded time window. A down-counter, advanced by a slow-clock enable through an internal prescaler, runs from a programmable reload value toward zero. Software services it by issuing a keyed restart command. The restart only counts when the counter has already fallen to or below a programmable window threshold. A restart that comes too early is flagged as a window error. A counter that runs out is flagged as an underflow.

Each fault sets a sticky status bit, which a status read clears. Depending on the configuration, a fault also raises a level interrupt and/or a one-cycle reset-request pulse toward the system reset logic. The configuration word can be accepted only once after reset. Out of reset, the timer already runs from its full range with the reset request enabled. An unconfigured system is therefore still protected.

Top module: `winwdt_top`

## Requirements
- R1: After reset the counter reads all ones (0xFFF at the default width), the reload value and the window threshold are all ones, the reset request is enabled, the interrupt is disabled, the timer is running, and both status bits, `irq` and `rst_req` are low.
- R2: The counter steps down by one on every 2^PRE_W-th cycle in which `slow_tick` is high (128 at the default). Cycles without `slow_tick` neither advance the prescaler nor the counter.
- R3: A control write (`ctl_wr`) with `ctl_restart` high and `ctl_key` equal to 0xA5 is accepted while the counter is at or below the window threshold. It reloads the counter from the reload value in the next cycle and clears the prescaler.
- R4: The same keyed restart while the counter is above the window threshold leaves the counter unchanged and sets the window-error status bit in the next cycle.
- R5: A control write whose key differs from 0xA5 changes neither the counter, the prescaler nor any status bit.
- R6: The step that takes the counter from 1 to 0 sets the underflow status bit in the same cycle the counter shows 0. The counter then holds at 0 until a restart or a mode load.
- R7: When the reset-request enable is set, `rst_req` is high for the single cycle after each fault. When the interrupt enable is set, `irq` is high while either status bit is set. With an enable cleared, the matching output stays low.
- R8: The first mode write after reset loads the reload value, threshold and flags and reloads the counter from the new reload value. Every later mode write is ignored.
- R9: A cycle with `stat_rd` high clears both status bits in the next cycle. A fault in that same cycle wins and leaves its bit set.
- R10: With the disable flag set, the counter and prescaler hold, restarts have no effect, and no fault, status bit, `irq` or `rst_req` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow-clock enable, one cycle per slow period |
| mode_wr | input | 1 | Mode write strobe (accepted once) |
| mode_reload | input | CNT_W | Counter reload value |
| mode_delta | input | CNT_W | Window threshold for valid restarts |
| mode_irq_en | input | 1 | Fault interrupt enable |
| mode_rst_en | input | 1 | Fault reset-request enable |
| mode_off | input | 1 | Disable: freeze counter, suppress faults |
| ctl_wr | input | 1 | Control write strobe |
| ctl_key | input | KEY_W | Key accompanying a control write |
| ctl_restart | input | 1 | Restart command bit of a control write |
| stat_rd | input | 1 | Status read strobe, clears status |
| count_o | output | CNT_W | Current counter value |
| stat_unf | output | 1 | Sticky underflow status |
| stat_err | output | 1 | Sticky window-error status |
| irq | output | 1 | Fault interrupt (level) |
| rst_req | output | 1 | Fault reset request (one-cycle pulse) |

## Verification
The bench builds the block with PRE_W = 2, so one counter step takes four slow ticks instead of 128. With that setting, a run down from a small reload value, and even the full 0xFFF run out of reset, fit in a short simulation. The counter width and the key keep their defaults, so the window comparisons, the key checks and the unconfigured underflow are tested at the real 12-bit range. The prescaler phase is tracked across restarts, and the one-cycle offsets of counter steps after a restart are checked exactly.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

    localparam int WDT_CNT_W = 12;
    localparam int WDT_PRE_W = 7;
    localparam int WDT_KEY_W = 8;

    typedef struct packed {
        logic irq_en;
        logic rst_en;
        logic off;
    } wdt_flags_t;

    localparam wdt_flags_t WDT_FLAGS_RST = '{irq_en: 1'b0, rst_en: 1'b1, off: 1'b0};

endpackage

// File: rtl/winwdt_prescale.sv
module winwdt_prescale #(
    parameter int PRE_W = winwdt_pkg::WDT_PRE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic step_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign step_o = tick_i && run_i && (&st_q.pre);

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.pre = '0;
        else if (tick_i && run_i)
            st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(st_q.pre));

endmodule

// File: rtl/winwdt_mode.sv
module winwdt_mode #(
    parameter int CNT_W = winwdt_pkg::WDT_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [CNT_W-1:0]       reload_i,
    input  logic [CNT_W-1:0]       delta_i,
    input  winwdt_pkg::wdt_flags_t flags_i,
    output logic [CNT_W-1:0]       reload_o,
    output logic [CNT_W-1:0]       delta_o,
    output winwdt_pkg::wdt_flags_t flags_o,
    output logic                   load_o
);
    typedef struct packed {
        logic [CNT_W-1:0]       reload;
        logic [CNT_W-1:0]       delta;
        winwdt_pkg::wdt_flags_t flags;
        logic                   lock;
    } mode_st_t;

    mode_st_t st_d, st_q;

    assign load_o   = wr_i && !st_q.lock;
    assign reload_o = st_q.reload;
    assign delta_o  = st_q.delta;
    assign flags_o  = st_q.flags;

    always_comb begin
        st_d = st_q;
        if (load_o) begin
            st_d.reload = reload_i;
            st_d.delta  = delta_i;
            st_d.flags  = flags_i;
            st_d.lock   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload <= '1;
            st_q.delta  <= '1;
            st_q.flags  <= winwdt_pkg::WDT_FLAGS_RST;
            st_q.lock   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.reload) && $stable(st_q.delta) && $stable(st_q.flags)));

endmodule

// File: rtl/winwdt_status.sv
module winwdt_status (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   unf_ev_i,
    input  logic                   err_ev_i,
    input  logic                   rd_i,
    input  winwdt_pkg::wdt_flags_t flags_i,
    output logic                   unf_o,
    output logic                   err_o,
    output logic                   irq_o,
    output logic                   rst_req_o
);
    typedef struct packed {
        logic unf;
        logic err;
        logic rreq;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.unf = 1'b0;
            st_d.err = 1'b0;
        end
        if (unf_ev_i) st_d.unf = 1'b1;
        if (err_ev_i) st_d.err = 1'b1;
        st_d.rreq = flags_i.rst_en && (unf_ev_i || err_ev_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unf_o     = st_q.unf;
    assign err_o     = st_q.err;
    assign rst_req_o = st_q.rreq;
    assign irq_o     = flags_i.irq_en && (st_q.unf || st_q.err);

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !unf_ev_i && !err_ev_i) |=> (!st_q.unf && !st_q.err));

    // R6
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_ev_i |=> st_q.unf);

endmodule

// File: rtl/winwdt_top.sv
module winwdt_top #(
    parameter int               CNT_W = winwdt_pkg::WDT_CNT_W,
    parameter int               PRE_W = winwdt_pkg::WDT_PRE_W,
    parameter int               KEY_W = winwdt_pkg::WDT_KEY_W,
    parameter logic [KEY_W-1:0] KEY   = 'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             mode_wr,
    input  logic [CNT_W-1:0] mode_reload,
    input  logic [CNT_W-1:0] mode_delta,
    input  logic             mode_irq_en,
    input  logic             mode_rst_en,
    input  logic             mode_off,
    input  logic             ctl_wr,
    input  logic [KEY_W-1:0] ctl_key,
    input  logic             ctl_restart,
    input  logic             stat_rd,
    output logic [CNT_W-1:0] count_o,
    output logic             stat_unf,
    output logic             stat_err,
    output logic             irq,
    output logic             rst_req
);
    import winwdt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    logic [CNT_W-1:0] cfg_reload, cfg_delta;
    wdt_flags_t       cfg_flags, new_flags;
    logic             mode_load, step, kick, kick_ok, unf_ev, err_ev;

    assign new_flags = '{irq_en: mode_irq_en, rst_en: mode_rst_en, off: mode_off};

    winwdt_mode #(.CNT_W(CNT_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (mode_wr),
        .reload_i (mode_reload),
        .delta_i  (mode_delta),
        .flags_i  (new_flags),
        .reload_o (cfg_reload),
        .delta_o  (cfg_delta),
        .flags_o  (cfg_flags),
        .load_o   (mode_load)
    );

    assign kick    = ctl_wr && ctl_restart && (ctl_key == KEY) && !cfg_flags.off && !mode_load;
    assign kick_ok = kick && (st_q.cnt <= cfg_delta);
    assign err_ev  = kick && (st_q.cnt > cfg_delta);

    winwdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (slow_tick),
        .run_i  (!cfg_flags.off),
        .clr_i  (mode_load || kick_ok),
        .step_o (step)
    );

    assign unf_ev = step && !mode_load && !kick_ok && (st_q.cnt == CNT_ONE);

    always_comb begin
        st_d = st_q;
        if (mode_load)
            st_d.cnt = mode_reload;
        else if (kick_ok)
            st_d.cnt = cfg_reload;
        else if (step && (st_q.cnt != '0))
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cnt <= '1;
        else        st_q     <= st_d;
    end

    winwdt_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .unf_ev_i  (unf_ev),
        .err_ev_i  (err_ev),
        .rd_i      (stat_rd),
        .flags_i   (cfg_flags),
        .unf_o     (stat_unf),
        .err_o     (stat_err),
        .irq_o     (irq),
        .rst_req_o (rst_req)
    );

    assign count_o = st_q.cnt;

    // R2
    cnt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |->
            ((st_q.cnt == $past(st_q.cnt) - 1'b1) || (st_q.cnt == cfg_reload)));

    // R4
    early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_restart && (ctl_key == KEY) && !mode_wr && !cfg_flags.off
         && (st_q.cnt > cfg_delta)) |=> ($stable(st_q.cnt) && stat_err));

    // R6
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt == '0) && !mode_wr && !ctl_wr) |=> (st_q.cnt == '0));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flags.off |=> (!rst_req && $stable(st_q.cnt)));

endmodule

// File: tb/sim_winwdt_top.sv
module sim_winwdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int          V_WAIT [NV] = '{40, 40, 2, 82, 3, 1};
    localparam logic [7:0]  V_KEY  [NV] = '{8'hA5, 8'hA5, 8'h00, 8'hA5, 8'hA5, 8'hA4};
    localparam int          V_ERR  [NV] = '{1, 0, 0, 0, 1, 0};
    localparam int          V_CNT  [NV] = '{30, 40, 40, 40, 40, 39};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0;
    logic mode_wr = 1'b0;
    logic [11:0] mode_reload = '0;
    logic [11:0] mode_delta = '0;
    logic mode_irq_en = 1'b0, mode_rst_en = 1'b0, mode_off = 1'b0;
    logic ctl_wr = 1'b0;
    logic [7:0] ctl_key = '0;
    logic ctl_restart = 1'b0;
    logic stat_rd = 1'b0;
    logic [11:0] count_o;
    logic stat_unf, stat_err, irq, rst_req;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    winwdt_top #(.PRE_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .mode_wr(mode_wr), .mode_reload(mode_reload), .mode_delta(mode_delta),
        .mode_irq_en(mode_irq_en), .mode_rst_en(mode_rst_en), .mode_off(mode_off),
        .ctl_wr(ctl_wr), .ctl_key(ctl_key), .ctl_restart(ctl_restart),
        .stat_rd(stat_rd), .count_o(count_o), .stat_unf(stat_unf),
        .stat_err(stat_err), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; slow_tick = 1'b0; mode_wr = 1'b0; ctl_wr = 1'b0;
        ctl_restart = 1'b0; stat_rd = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic ticks(input int n);
        slow_tick = 1'b1;
        repeat (n) cyc();
        slow_tick = 1'b0;
    endtask

    task automatic kick(input logic [7:0] k);
        ctl_wr = 1'b1; ctl_key = k; ctl_restart = 1'b1;
        cyc();
        ctl_wr = 1'b0; ctl_restart = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1;
        cyc();
        stat_rd = 1'b0;
    endtask

    task automatic wr_mode(input int rl, input int dl, input bit ie, input bit re, input bit off);
        mode_reload = rl[11:0]; mode_delta = dl[11:0];
        mode_irq_en = ie; mode_rst_en = re; mode_off = off;
        mode_wr = 1'b1;
        cyc();
        mode_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int seen;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 count", count_o, 12'hFFF);
        chk("R1 unf", stat_unf, 0);
        chk("R1 err", stat_err, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R2 no ticks -> hold; 8 ticks -> two steps
        repeat (20) cyc();
        chk("R2 hold without tick", count_o, 12'hFFF);
        ticks(8);
        chk("R2 two steps", count_o, 12'hFFD);

        // R5 wrong key
        kick(8'h5A);
        chk("R5 count", count_o, 12'hFFD);
        chk("R5 err", stat_err, 0);

        // R8 first write loads, second ignored
        wr_mode(40, 20, 1'b1, 1'b0, 1'b0);
        chk("R8 load", count_o, 40);
        wr_mode(100, 4000, 1'b0, 1'b1, 1'b1);
        chk("R8 second ignored", count_o, 40);

        // table: R3 R4 R5 R7 R9
        for (int i = 0; i < NV; i++) begin
            ticks(V_WAIT[i]);
            kick(V_KEY[i]);
            chk($sformatf("R3/R4 vec%0d count", i), count_o, V_CNT[i]);
            chk($sformatf("R4 vec%0d err", i), stat_err, V_ERR[i]);
            chk($sformatf("R7 vec%0d irq", i), irq, V_ERR[i]);
            chk($sformatf("R7 vec%0d rst_req off", i), rst_req, 0);
            rd_stat();
            chk($sformatf("R9 vec%0d cleared", i), stat_err, 0);
        end

        // R6 underflow from 39
        ticks(155);
        chk("R6 count at one", count_o, 1);
        chk("R6 no unf yet", stat_unf, 0);
        ticks(1);
        chk("R6 count zero", count_o, 0);
        chk("R6 unf set", stat_unf, 1);
        chk("R7 irq on unf", irq, 1);
        chk("R7 no rst_req when disabled", rst_req, 0);
        ticks(8);
        chk("R6 holds zero", count_o, 0);
        rd_stat();
        chk("R9 unf cleared", stat_unf, 0);
        chk("R9 irq low", irq, 0);
        kick(8'hA5);
        chk("R3 restart from zero", count_o, 40);

        // R1 R7 unconfigured watchdog fires with reset request
        do_reset();
        slow_tick = 1'b1;
        seen = 0;
        for (int c = 0; c < 20000 && seen == 0; c++) begin
            cyc();
            if (stat_unf) begin
                seen = 1;
                chk("R7 rst_req with unf", rst_req, 1);
                chk("R7 irq disabled by default", irq, 0);
                chk("R1 full run length", c + 1, 16380);
            end
        end
        chk("R1 default underflow seen", seen, 1);
        cyc();
        chk("R7 rst_req one cycle", rst_req, 0);
        slow_tick = 1'b0;

        // R10 disabled
        do_reset();
        wr_mode(10, 5, 1'b1, 1'b1, 1'b1);
        ticks(100);
        chk("R10 count frozen", count_o, 10);
        kick(8'hA5);
        chk("R10 no err", stat_err, 0);
        chk("R10 no rst_req", rst_req, 0);
        chk("R10 count after kick", count_o, 10);
        chk("R10 no unf", stat_unf, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule